// File: doc/BRIEF.md
# Processor Stack and Status Unit

This unit keeps the stack pointer and the flag register of a small 8-bit processor. The instruction sequencer sends it one command strobe at a time: push or pull a byte, push or pull a 16-bit word, push or pull the flag byte, return from interrupt, or move the pointer to or from the X register. The unit breaks each command into single-byte accesses on a synchronous memory port. The stack sits in one fixed 256-byte page and grows downward. The unit returns any pulled data with a one-cycle done pulse.

Apart from the stack commands, the flag register takes single-bit set and clear requests and masked flag updates from the ALU. When the flags are pushed, two bits are forced high in the stored copy. When the flags are pulled back, those same two bits are dropped.

Top module: `stack_status_unit`

## Requirements
- R1: After synchronous reset the pointer reads 0xFD, the flag register reads 0x24 (interrupt disable and bit 5 only) and busy is low.
- R2: Flag bits from bit 0 upward are carry, zero, interrupt disable, decimal, break, spare (bit 5), overflow and negative. A flag request with index `fl_op_idx` and value `fl_op_val` changes only that bit, on the next clock edge.
- R3: Every memory access addresses 0x0100 plus a pointer value. A write uses the current pointer. A read uses the pointer plus one, modulo 256.
- R4: A push writes the current stack address and then decrements the pointer modulo 256, so a push at 0x00 leaves 0xFF.
- R5: A pull increments the pointer modulo 256 and then reads, so a pull at 0xFF reads address 0x0100. A byte pull returns the byte on `pull_data[7:0]` with the upper byte zero.
- R6: A word push stores the high byte and then the low byte. A word pull reads the low byte and then the high byte, and returns them as `{high, low}`.
- R7: A flag push writes the flag register OR 0x30 and leaves the held register unchanged.
- R8: A flag pull loads the read byte AND 0xCF. A return from interrupt does this flag pull first, then pulls a word returned on `pull_data`.
- R9: A move from pointer to X puts the pointer on `x_out` with `x_we` during done, and sets zero and negative from that value. A move from X to pointer loads `x_in` and leaves all flags unchanged.
- R10: An ALU update copies the `alu_flags` bits selected by `alu_mask`. A flag request in the same cycle wins on its own bit. A flag load from a stack pull wins over both.
- R11: Commands are accepted only while busy is low. A command strobe while busy, or an unknown command code, causes no memory access and no state change. Codes: 1 push byte, 2 pull byte, 3 push word, 4 pull word, 5 push flags, 6 pull flags, 7 return from interrupt, 8 pointer to X, 9 X to pointer.
- R12: Each access takes one cycle, and read data arrives one cycle after its request. Done follows acceptance after 2 cycles for byte and flag pushes, 3 for word push, 3 for byte and flag pulls, 5 for word pull, 7 for return from interrupt, and 1 for transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (see R11) |
| cmd_word | input | 16 | Push data: byte in [7:0], word as {high, low} |
| x_in | input | 8 | X register value for the X-to-pointer move |
| fl_op_en | input | 1 | Single flag write request |
| fl_op_idx | input | 3 | Flag bit index |
| fl_op_val | input | 1 | Value written to that flag |
| alu_en | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Flag bits the ALU updates |
| alu_flags | input | 8 | New flag values from the ALU |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_data | output | 16 | Pulled byte or word |
| x_out | output | 8 | Pointer value for X |
| x_we | output | 1 | X write strobe |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Flag register |

## Verification
A wrong pointer shows up at once on the address of the next access, and stays wrong in every later done check, because all addresses derive from it. A wrong byte order or a missed pointer step shows up when the data is pulled back: the returned word comes out swapped or shifted within one command. A wrong flag merge priority, or a flag that fails to drop bits 4 and 5, is visible on `status_out` in the done cycle of the command that caused it. A command taken while busy shows up as an extra memory access in the very next cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] SP_AT_RESET = 8'hFD;
    localparam logic [BYTE_W-1:0] FL_AT_RESET = 8'h24;
    localparam logic [BYTE_W-1:0] STACK_PAGE  = 8'h01;
    localparam logic [BYTE_W-1:0] PUSH_FORCE  = 8'h30;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_S = 5;
    localparam int FL_V = 6;
    localparam int FL_N = 7;

    typedef enum logic [3:0] {
        C_NONE    = 4'd0,
        C_PUSH_B  = 4'd1,
        C_PULL_B  = 4'd2,
        C_PUSH_W  = 4'd3,
        C_PULL_W  = 4'd4,
        C_PUSH_FL = 4'd5,
        C_PULL_FL = 4'd6,
        C_RETI    = 4'd7,
        C_SP2X    = 4'd8,
        C_X2SP    = 4'd9
    } stk_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACC,
        S_RD,
        S_FIN
    } stk_state_e;

    function automatic logic cmd_known(input logic [3:0] code);
        return (code >= 4'd1) && (code <= 4'd9);
    endfunction

    function automatic logic cmd_is_push(input stk_cmd_e c);
        return (c == C_PUSH_B) || (c == C_PUSH_W) || (c == C_PUSH_FL);
    endfunction

    function automatic logic cmd_is_pull(input stk_cmd_e c);
        return (c == C_PULL_B) || (c == C_PULL_W) || (c == C_PULL_FL) || (c == C_RETI);
    endfunction

    function automatic logic [1:0] cmd_bytes(input stk_cmd_e c);
        case (c)
            C_PUSH_B, C_PULL_B, C_PUSH_FL, C_PULL_FL: return 2'd1;
            C_PUSH_W, C_PULL_W:                       return 2'd2;
            C_RETI:                                   return 2'd3;
            default:                                  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE   = STACK_PAGE,
    parameter logic [BYTE_W-1:0] RST_SP = SP_AT_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_en,
    input  logic              inc_en,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] sp,
    output logic [WORD_W-1:0] push_addr,
    output logic [WORD_W-1:0] pull_addr
);

    logic [BYTE_W-1:0] sp_q;
    logic [BYTE_W-1:0] sp_plus;

    assign sp_plus   = sp_q + 8'd1;
    assign sp        = sp_q;
    assign push_addr = {PAGE, sp_q};
    assign pull_addr = {PAGE, sp_plus};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= RST_SP;
        end else if (load_en) begin
            sp_q <= load_val;
        end else if (dec_en) begin
            sp_q <= sp_q - 8'd1;
        end else if (inc_en) begin
            sp_q <= sp_plus;
        end
    end

    // R4 / R5: the sequencer never asks for two pointer moves at once
    a_r4_one_move: assert property (@(posedge clk) disable iff (rst)
        $countones({dec_en, inc_en, load_en}) <= 1);

endmodule

// File: rtl/stk_flags.sv
module stk_flags
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_FL = FL_AT_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_en,
    input  logic [BYTE_W-1:0] alu_mask,
    input  logic [BYTE_W-1:0] alu_val,
    input  logic              fop_en,
    input  logic [2:0]        fop_idx,
    input  logic              fop_val,
    input  logic              zn_en,
    input  logic [BYTE_W-1:0] zn_val,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] flags
);

    logic [BYTE_W-1:0] fl_q;
    logic [BYTE_W-1:0] fl_d;

    always_comb begin
        fl_d = fl_q;
        if (alu_en) begin
            fl_d = (fl_d & ~alu_mask) | (alu_val & alu_mask);
        end
        if (fop_en) begin
            fl_d[fop_idx] = fop_val;
        end
        if (zn_en) begin
            fl_d[FL_Z] = (zn_val == '0);
            fl_d[FL_N] = zn_val[BYTE_W-1];
        end
        if (load_en) begin
            fl_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= RST_FL;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    // R8: a loaded flag byte never keeps bits 4 and 5
    a_r8_pull_drops_b: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (fl_q[FL_S:FL_B] == 2'b00));

    // R10: with no update source the register holds
    a_r10_quiet_holds: assert property (@(posedge clk) disable iff (rst)
        !(alu_en || fop_en || zn_en || load_en) |=> $stable(fl_q));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [BYTE_W-1:0] x_in,
    input  logic [BYTE_W-1:0] sp,
    input  logic [BYTE_W-1:0] flags,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] push_addr,
    input  logic [WORD_W-1:0] pull_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sp_dec,
    output logic              sp_inc,
    output logic              sp_load,
    output logic [BYTE_W-1:0] sp_load_val,
    output logic              fl_load,
    output logic [BYTE_W-1:0] fl_load_val,
    output logic              zn_en,
    output logic [BYTE_W-1:0] zn_val,
    output logic              busy,
    output logic              done,
    output logic              x_we,
    output logic [BYTE_W-1:0] x_out,
    output logic [WORD_W-1:0] pull_data
);

    stk_state_e        state_q, state_d;
    stk_cmd_e          cmd_q;
    stk_cmd_e          cmd_in;
    logic [1:0]        step_q;
    logic [1:0]        last_q;
    logic [1:0]        slot;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] pd_q;
    logic [BYTE_W-1:0] x_q;
    logic [BYTE_W-1:0] wbyte;
    logic              accept;
    logic              fl_step;
    logic              last_step;

    assign cmd_in    = stk_cmd_e'(cmd_code);
    assign accept    = (state_q == S_IDLE) && cmd_valid && cmd_known(cmd_code);
    assign fl_step   = (cmd_q == C_PULL_FL) || ((cmd_q == C_RETI) && (step_q == 2'd0));
    assign slot      = (cmd_q == C_RETI) ? (step_q - 2'd1) : step_q;
    assign last_step = (step_q == last_q);

    always_comb begin
        case (cmd_q)
            C_PUSH_W:  wbyte = (step_q == 2'd0) ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
            C_PUSH_FL: wbyte = flags | PUSH_FORCE;
            default:   wbyte = word_q[BYTE_W-1:0];
        endcase
    end

    always_comb begin
        state_d     = state_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = pull_addr;
        mem_wdata   = '0;
        sp_dec      = 1'b0;
        sp_inc      = 1'b0;
        sp_load     = 1'b0;
        sp_load_val = x_in;
        fl_load     = 1'b0;
        fl_load_val = mem_rdata & ~PUSH_FORCE;
        zn_en       = 1'b0;
        zn_val      = sp;
        case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (cmd_in == C_SP2X) begin
                        zn_en   = 1'b1;
                        state_d = S_FIN;
                    end else if (cmd_in == C_X2SP) begin
                        sp_load = 1'b1;
                        state_d = S_FIN;
                    end else begin
                        state_d = S_ACC;
                    end
                end
            end
            S_ACC: begin
                mem_req = 1'b1;
                if (cmd_is_push(cmd_q)) begin
                    mem_we    = 1'b1;
                    mem_addr  = push_addr;
                    mem_wdata = wbyte;
                    sp_dec    = 1'b1;
                    state_d   = last_step ? S_FIN : S_ACC;
                end else begin
                    sp_inc  = 1'b1;
                    state_d = S_RD;
                end
            end
            S_RD: begin
                fl_load = fl_step;
                state_d = last_step ? S_FIN : S_ACC;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cmd_q   <= C_NONE;
            step_q  <= '0;
            last_q  <= '0;
            word_q  <= '0;
            pd_q    <= '0;
            x_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_q  <= cmd_in;
                step_q <= '0;
                last_q <= cmd_bytes(cmd_in) - 2'd1;
                word_q <= cmd_word;
                if (cmd_is_pull(cmd_in)) begin
                    pd_q <= '0;
                end
                if (cmd_in == C_SP2X) begin
                    x_q <= sp;
                end
            end
            if ((state_q == S_ACC) && mem_we) begin
                step_q <= step_q + 2'd1;
            end
            if (state_q == S_RD) begin
                if (!fl_step) begin
                    if (slot[0]) begin
                        pd_q[WORD_W-1:BYTE_W] <= mem_rdata;
                    end else begin
                        pd_q[BYTE_W-1:0] <= mem_rdata;
                    end
                end
                step_q <= step_q + 2'd1;
            end
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FIN);
    assign x_we      = done && (cmd_q == C_SP2X);
    assign x_out     = x_q;
    assign pull_data = pd_q;

    // R11: a strobe while busy leaves the running command untouched
    a_r11_busy_holds_cmd: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> $stable(cmd_q));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: every read request is followed by a data-capture cycle
    a_r12_read_then_capture: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (state_q == S_RD));

    // R7: a pushed flag byte carries bits 4 and 5 set
    a_r7_push_fl_bits: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && (cmd_q == C_PUSH_FL)) |-> (mem_wdata[FL_S:FL_B] == 2'b11));

endmodule

// File: rtl/stack_status_unit.sv
module stack_status_unit
    import stk_pkg::*;
#(
    parameter logic [7:0] PAGE   = STACK_PAGE,
    parameter logic [7:0] RST_SP = SP_AT_RESET,
    parameter logic [7:0] RST_FL = FL_AT_RESET
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_code,
    input  logic [15:0] cmd_word,
    input  logic [7:0]  x_in,
    input  logic        fl_op_en,
    input  logic [2:0]  fl_op_idx,
    input  logic        fl_op_val,
    input  logic        alu_en,
    input  logic [7:0]  alu_mask,
    input  logic [7:0]  alu_flags,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pull_data,
    output logic [7:0]  x_out,
    output logic        x_we,
    output logic [7:0]  sp_out,
    output logic [7:0]  status_out
);

    logic              sp_dec, sp_inc, sp_load;
    logic [BYTE_W-1:0] sp_load_val;
    logic              fl_load, zn_en;
    logic [BYTE_W-1:0] fl_load_val, zn_val;
    logic [WORD_W-1:0] push_addr, pull_addr;

    stk_ptr #(
        .PAGE   (PAGE),
        .RST_SP (RST_SP)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .dec_en    (sp_dec),
        .inc_en    (sp_inc),
        .load_en   (sp_load),
        .load_val  (sp_load_val),
        .sp        (sp_out),
        .push_addr (push_addr),
        .pull_addr (pull_addr)
    );

    stk_flags #(
        .RST_FL (RST_FL)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .alu_en   (alu_en),
        .alu_mask (alu_mask),
        .alu_val  (alu_flags),
        .fop_en   (fl_op_en),
        .fop_idx  (fl_op_idx),
        .fop_val  (fl_op_val),
        .zn_en    (zn_en),
        .zn_val   (zn_val),
        .load_en  (fl_load),
        .load_val (fl_load_val),
        .flags    (status_out)
    );

    stk_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .cmd_word    (cmd_word),
        .x_in        (x_in),
        .sp          (sp_out),
        .flags       (status_out),
        .mem_rdata   (mem_rdata),
        .push_addr   (push_addr),
        .pull_addr   (pull_addr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .sp_dec      (sp_dec),
        .sp_inc      (sp_inc),
        .sp_load     (sp_load),
        .sp_load_val (sp_load_val),
        .fl_load     (fl_load),
        .fl_load_val (fl_load_val),
        .zn_en       (zn_en),
        .zn_val      (zn_val),
        .busy        (busy),
        .done        (done),
        .x_we        (x_we),
        .x_out       (x_out),
        .pull_data   (pull_data)
    );

    // R3: writes hit the page at the current pointer
    a_r3_write_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == {PAGE, sp_out}));

    // R3: reads hit the page at pointer plus one
    a_r3_read_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr == {PAGE, sp_out + 8'd1}));

    // R4: a write leaves the pointer one lower
    a_r4_push_dec: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (sp_out == $past(sp_out) - 8'd1));

    // R5: a read leaves the pointer one higher
    a_r5_pull_inc: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (sp_out == $past(sp_out) + 8'd1));

endmodule

// File: tb/stack_status_unit_tb.sv
module stack_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic [15:0] cmd_word = 16'd0;
    logic [7:0]  x_in = 8'd0;
    logic        fl_op_en = 1'b0;
    logic [2:0]  fl_op_idx = 3'd0;
    logic        fl_op_val = 1'b0;
    logic        alu_en = 1'b0;
    logic [7:0]  alu_mask = 8'd0;
    logic [7:0]  alu_flags = 8'd0;
    logic        mem_req, mem_we, busy, done, x_we;
    logic [15:0] mem_addr, pull_data;
    logic [7:0]  mem_wdata, x_out, sp_out, status_out;
    logic [7:0]  mem_rdata = 8'd0;

    always #2.5 clk = ~clk;

    stack_status_unit u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_word(cmd_word), .x_in(x_in), .fl_op_en(fl_op_en), .fl_op_idx(fl_op_idx),
        .fl_op_val(fl_op_val), .alu_en(alu_en), .alu_mask(alu_mask), .alu_flags(alu_flags),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pull_data(pull_data),
        .x_out(x_out), .x_we(x_we), .sp_out(sp_out), .status_out(status_out)
    );

    // memory: read data one cycle after request
    logic [7:0] ram  [256];
    logic [7:0] mref [256];
    always @(posedge clk) begin
        if (mem_req && mem_we)  ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[7:0]];
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind 0 write, 1 read, 2 done
    typedef struct {
        int    kind;
        int    a;
        int    b;
        int    c;
        int    d;
        string tag;
    } exp_t;
    exp_t expq[$];
    exp_t it;

    logic [7:0] m_sp = 8'hFD;
    logic [7:0] m_st = 8'h24;

    task automatic mpush(input logic [7:0] v, input string tag);
        exp_t e;
        e.kind = 0; e.a = 32'h100 + int'(m_sp); e.b = int'(v); e.c = 0; e.d = 0; e.tag = tag;
        expq.push_back(e);
        mref[m_sp] = v;
        m_sp = m_sp - 8'd1;
    endtask

    task automatic mpull(output logic [7:0] v, input string tag);
        exp_t e;
        m_sp = m_sp + 8'd1;
        e.kind = 1; e.a = 32'h100 + int'(m_sp); e.b = 0; e.c = 0; e.d = 0; e.tag = tag;
        expq.push_back(e);
        v = mref[m_sp];
    endtask

    function automatic int exp_lat(input int code);
        case (code)
            1, 5:    return 2;
            3:       return 3;
            2, 6:    return 3;
            4:       return 5;
            7:       return 7;
            default: return 1;
        endcase
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                if (expq.size() == 0 || expq[0].kind == 2) begin
                    chk(1'b0, "R11 unexpected memory access", int'(mem_addr), -1);
                end else begin
                    it = expq.pop_front();
                    chk(it.kind == (mem_we ? 0 : 1), {it.tag, " access direction"}, int'(mem_we), it.kind == 0 ? 1 : 0);
                    chk(int'(mem_addr) == it.a, {it.tag, " R3 address"}, int'(mem_addr), it.a);
                    if (mem_we) chk(int'(mem_wdata) == it.b, {it.tag, " write data"}, int'(mem_wdata), it.b);
                end
            end
            if (done) begin
                if (expq.size() == 0 || expq[0].kind != 2) begin
                    chk(1'b0, "R12 done out of order", 1, 0);
                end else begin
                    it = expq.pop_front();
                    if (it.a >= 0) chk(int'(pull_data) == it.a, {it.tag, " pull_data"}, int'(pull_data), it.a);
                    chk(int'(sp_out) == it.b, {it.tag, " pointer"}, int'(sp_out), it.b);
                    chk(int'(status_out) == it.c, {it.tag, " flags"}, int'(status_out), it.c);
                    if (it.d >= 0) begin
                        chk(x_we == 1'b1, {it.tag, " R9 x_we"}, int'(x_we), 1);
                        chk(int'(x_out) == it.d, {it.tag, " R9 x_out"}, int'(x_out), it.d);
                    end
                end
            end
        end
    end

    task automatic do_cmd(input int code, input logic [15:0] w, input int intr, input string tag);
        exp_t e;
        logic [7:0] lo, hi, t;
        int pd = -1;
        int xv = -1;
        int lat;
        lo = 8'd0; hi = 8'd0; t = 8'd0;
        case (code)
            1: mpush(w[7:0], tag);
            3: begin mpush(w[15:8], tag); mpush(w[7:0], tag); end
            5: mpush(m_st | 8'h30, tag);
            2: begin mpull(lo, tag); pd = int'(lo); end
            4: begin mpull(lo, tag); mpull(hi, tag); pd = int'({hi, lo}); end
            6: begin mpull(t, tag); m_st = t & 8'hCF; pd = 0; end
            7: begin mpull(t, tag); m_st = t & 8'hCF; mpull(lo, tag); mpull(hi, tag); pd = int'({hi, lo}); end
            8: begin xv = int'(m_sp); m_st[1] = (m_sp == 8'd0); m_st[7] = m_sp[7]; end
            9: m_sp = x_in;
            default: ;
        endcase
        e.kind = 2; e.a = pd; e.b = int'(m_sp); e.c = int'(m_st); e.d = xv; e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'(code); cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intr > 0) begin
            cmd_valid = 1'b1; cmd_code = 4'(intr); cmd_word = 16'h00EE;
        end
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            lat++;
        end
        chk(lat == exp_lat(code), {tag, " R12 latency"}, lat, exp_lat(code));
    endtask

    task automatic flag_op(input int idx, input bit v, input string tag);
        @(negedge clk);
        fl_op_en = 1'b1; fl_op_idx = 3'(idx); fl_op_val = v;
        @(negedge clk);
        fl_op_en = 1'b0;
        m_st[idx] = v;
        chk(status_out == m_st, tag, int'(status_out), int'(m_st));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]  = 8'(i * 7 + 3);
            mref[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(sp_out == 8'hFD, "R1 reset pointer", int'(sp_out), 'hFD);
        chk(status_out == 8'h24, "R1 reset flags", int'(status_out), 'h24);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);

        do_cmd(1, 16'h00A5, 0, "R4 push byte");
        do_cmd(3, 16'h1234, 0, "R6 push word");
        do_cmd(4, 16'h0000, 0, "R6 pull word");
        do_cmd(2, 16'h0000, 0, "R5 pull byte");

        flag_op(0, 1'b1, "R2 set carry");
        flag_op(3, 1'b1, "R2 set decimal");
        flag_op(2, 1'b0, "R2 clear irq disable");
        flag_op(6, 1'b1, "R2 set overflow");

        do_cmd(5, 16'h0000, 0, "R7 push flags");

        // R10: ALU merge with same-cycle flag request on carry
        @(negedge clk);
        alu_en = 1'b1; alu_mask = 8'hC3; alu_flags = 8'h81;
        fl_op_en = 1'b1; fl_op_idx = 3'd0; fl_op_val = 1'b0;
        @(negedge clk);
        alu_en = 1'b0; fl_op_en = 1'b0;
        m_st = (m_st & ~8'hC3) | (8'h81 & 8'hC3);
        m_st[0] = 1'b0;
        chk(status_out == m_st, "R10 alu merge with flag request", int'(status_out), int'(m_st));

        do_cmd(6, 16'h0000, 0, "R8 pull flags");

        do_cmd(3, 16'hBEEF, 0, "R8 setup word");
        do_cmd(1, 16'h00F3, 0, "R8 setup flag byte");
        do_cmd(7, 16'h0000, 0, "R8 return from interrupt");

        // R10: stack flag load beats an all-ones ALU update
        do_cmd(1, 16'h005A, 0, "R10 setup");
        @(negedge clk);
        alu_en = 1'b1; alu_mask = 8'hFF; alu_flags = 8'hFF;
        do_cmd(6, 16'h0000, 0, "R10 load beats alu");
        alu_en = 1'b0;
        @(negedge clk);

        // R4 / R5 wrap
        x_in = 8'h00;
        do_cmd(9, 16'h0000, 0, "R9 x to pointer zero");
        do_cmd(1, 16'h0077, 0, "R4 push wraps");
        do_cmd(2, 16'h0000, 0, "R5 pull wraps");

        // R9 flags from pointer
        x_in = 8'h80;
        do_cmd(9, 16'h0000, 0, "R9 x to pointer 80");
        do_cmd(8, 16'h0000, 0, "R9 pointer to x negative");
        x_in = 8'h00;
        do_cmd(9, 16'h0000, 0, "R9 x to pointer 00");
        do_cmd(8, 16'h0000, 0, "R9 pointer to x zero");

        // R11: strobe while busy ignored
        x_in = 8'hF0;
        do_cmd(9, 16'h0000, 0, "R11 setup");
        do_cmd(4, 16'h0000, 1, "R11 busy strobe ignored");
        repeat (3) @(negedge clk);
        chk(sp_out == m_sp, "R11 pointer after busy strobe", int'(sp_out), int'(m_sp));

        // R11: unknown code ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'hF;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R11 unknown code busy", int'(busy), 0);
        repeat (2) @(negedge clk);
        chk(sp_out == m_sp, "R11 unknown code pointer", int'(sp_out), int'(m_sp));
        chk(status_out == m_st, "R11 unknown code flags", int'(status_out), int'(m_st));

        chk(expq.size() == 0, "R12 all expected accesses seen", expq.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule